// File: doc/BRIEF.md
# Start-Bit Framed Converter Serial Port

This block is the digital serial front end of a 12-bit data converter. A host drives a chip-select (`cs_n`), a serial clock (`sclk`) and a serial data line (`din`) and reads results back on `dout`. All three pins are brought into the block's own system clock domain through synchronizers, and edges of `sclk` are detected there, so the serial clock must run well below the system clock.

Framing does not rely on a fixed bit count from chip-select. While the port is idle, zeros on `din` are skipped, and the first one sampled begins an 8-bit control byte. That byte selects an input channel, an input range and polarity, and a low-power mode. Completing a byte issues a one-cycle conversion request. On the next falling serial edge, the most recently captured converter result is loaded into an output shifter and sent MSB first. In unipolar mode it goes out as straight binary. In bipolar mode it goes out as two's complement.

While a result is being read out, a new start bit is accepted once result bit D4 is on the line. This lets the next control byte overlap the tail of the current readout.

Top module: `sadc_serial_if`

## Requirements
- R1: `din` is sampled only on rising `sclk` edges while `cs_n` is low. Zeros sampled while hunting are skipped. The first one sampled is the start bit and becomes bit 7 of the control byte.
- R2: The control byte is taken MSB first as bit 7 = start, bits 6:4 = channel (`conv_chan`), bit 3 = range select, bit 2 = polarity select. `rng_sel` = {bit 3, bit 2}, where 00 is small unipolar, 01 is small bipolar, 10 is large unipolar and 11 is large bipolar. `bipolar` equals bit 2.
- R3: Each completed control byte raises `conv_req` for exactly one clock. The decoded outputs change only in that same cycle.
- R4: `pd_in` is captured into a power-down-disable bit when a byte completes; that bit is 1 after reset. The `pwr_mode` codes are as follows. When the bit is 1, the code is 0 (normal) and mode bits 1:0 are ignored. When the bit is 0, mode 00 gives 1 (immediate standby), 01 gives 2 (delayed standby), 10 gives 3 (delayed full power-down) and 11 gives 4 (immediate full power-down).
- R5: On the first falling `sclk` edge after a byte completes, the result is loaded and bit 11 appears on `dout`. Each later falling edge presents the next lower bit.
- R6: In unipolar mode, `dout` carries `res_data` unchanged. In bipolar mode, bit 11 of the offset-binary `res_data` is inverted, which gives two's complement.
- R7: Once all 12 bits have been sent, `dout` is 0 for as long as `cs_n` stays low.
- R8: During a readout, ones on `din` at rising edges before bit D4 has been driven are ignored. No request is issued and the readout is unaffected.
- R9: From the rising edge at which D4 is on `dout`, a one on `din` starts a new control byte. The old readout continues, and the new result follows at the falling edge after the new byte completes.
- R10: `cs_n` high aborts any partial byte and readout. No request is issued, the decoded outputs keep their values, and `dout_oe` and `dout` go to 0.
- R11: After reset, `dout`, `dout_oe`, `conv_req`, `conv_chan`, `rng_sel` and `bipolar` are 0 and `pwr_mode` is 0.
- R12: `res_data` is captured while `res_valid` is high. A load uses the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial control data from host |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for the `dout` pad |
| res_data | input | 12 | Converter result, offset binary |
| res_valid | input | 1 | Result capture strobe |
| pd_in | input | 1 | Power-down-disable value taken at byte completion |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Selected channel |
| rng_sel | output | 2 | Range and polarity code |
| bipolar | output | 1 | Polarity select |
| pwr_mode | output | 3 | Power mode code |

## Verification
The bench builds the block with its defaults: a 12-bit result, an 8-bit control byte, two synchronizer stages and an overlap point at D4. With those values, one chip-select window can hold two complete transfers. The bench drives ones on `din` throughout the forbidden part of a readout and then starts the second byte at the first allowed edge. Both result words are checked bit by bit across the overlap.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;

  typedef enum logic [2:0] {
    PM_NORMAL   = 3'd0,
    PM_STBY_IMM = 3'd1,
    PM_STBY_DLY = 3'd2,
    PM_FULL_DLY = 3'd3,
    PM_FULL_IMM = 3'd4
  } pwr_mode_e;

  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_PEND = 2'd1,
    TX_SEND = 2'd2
  } tx_state_e;

  function automatic pwr_mode_e decode_pwr(input logic pd, input logic [1:0] mode);
    if (pd) return PM_NORMAL;
    case (mode)
      2'b00:   return PM_STBY_IMM;
      2'b01:   return PM_STBY_DLY;
      2'b10:   return PM_FULL_DLY;
      default: return PM_FULL_IMM;
    endcase
  endfunction

endpackage

// File: rtl/sadc_pin_sync.sv
`timescale 1ns/1ps
module sadc_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sclk,
  input  logic din,
  output logic active,
  output logic rise,
  output logic fall,
  output logic din_s
);
  // bit 0 = cs_n, bit 1 = sclk, bit 2 = din
  logic [2:0] stg [STAGES];
  logic       sclk_d;
  logic       sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= 3'b001;
      sclk_d <= 1'b0;
    end else begin
      stg[0] <= {din, sclk, cs_n};
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      sclk_d <= stg[STAGES-1][1];
    end
  end

  assign sclk_s = stg[STAGES-1][1];
  assign active = ~stg[STAGES-1][0];
  assign din_s  = stg[STAGES-1][2];
  assign rise   = active & sclk_s & ~sclk_d;
  assign fall   = active & ~sclk_s & sclk_d;

endmodule

// File: rtl/sadc_framer.sv
`timescale 1ns/1ps
module sadc_framer #(
  parameter int CTRL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              rise,
  input  logic              din_s,
  input  logic              hunt_en,
  output logic              shifting,
  output logic              byte_done,
  output logic [CTRL_W-1:0] byte_q
);
  localparam int CNT_W = $clog2(CTRL_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CTRL_W - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      shifting  <= 1'b0;
      cnt       <= '0;
      byte_done <= 1'b0;
      if (rst) byte_q <= '0;
    end else begin
      byte_done <= 1'b0;
      if (rise) begin
        if (!shifting) begin
          if (hunt_en && din_s) begin
            shifting <= 1'b1;
            byte_q   <= CTRL_W'(1);
            cnt      <= CNT_W'(1);
          end
        end else begin
          byte_q <= {byte_q[CTRL_W-2:0], din_s};
          if (cnt == LAST) begin
            shifting  <= 1'b0;
            byte_done <= 1'b1;
            cnt       <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/sadc_tx.sv
`timescale 1ns/1ps
module sadc_tx
  import sadc_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int OVL_BIT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             fall,
  input  logic             load_req,
  input  logic [RES_W-1:0] load_word,
  output logic             dout,
  output logic             hunt_en
);
  localparam int BC_W = $clog2(RES_W);
  localparam logic [BC_W-1:0] LAST_IDX = BC_W'(RES_W - 1);
  localparam logic [BC_W-1:0] OPEN_IDX = BC_W'(RES_W - 1 - OVL_BIT);

  tx_state_e        st;
  logic [RES_W-1:0] sr;
  logic [BC_W-1:0]  bitcnt;

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      st     <= TX_IDLE;
      sr     <= '0;
      bitcnt <= '0;
      dout   <= 1'b0;
    end else if (load_req) begin
      st <= TX_PEND;
    end else if (fall) begin
      case (st)
        TX_PEND: begin
          sr     <= load_word;
          dout   <= load_word[RES_W-1];
          bitcnt <= '0;
          st     <= TX_SEND;
        end
        TX_SEND: begin
          if (bitcnt == LAST_IDX) begin
            dout <= 1'b0;
            st   <= TX_IDLE;
          end else begin
            dout   <= sr[RES_W-2];
            sr     <= sr << 1;
            bitcnt <= bitcnt + BC_W'(1);
          end
        end
        default: dout <= 1'b0;
      endcase
    end
  end

  assign hunt_en = (st == TX_IDLE) || ((st == TX_SEND) && (bitcnt >= OPEN_IDX));

endmodule

// File: rtl/sadc_serial_if.sv
`timescale 1ns/1ps
module sadc_serial_if
  import sadc_pkg::*;
#(
  parameter int RES_W       = 12,
  parameter int CTRL_W      = 8,
  parameter int CHAN_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int OVL_BIT     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  output logic              dout,
  output logic              dout_oe,
  input  logic [RES_W-1:0]  res_data,
  input  logic              res_valid,
  input  logic              pd_in,
  output logic              conv_req,
  output logic [CHAN_W-1:0] conv_chan,
  output logic [1:0]        rng_sel,
  output logic              bipolar,
  output logic [2:0]        pwr_mode
);
  localparam int CHAN_HI = CTRL_W - 2;
  localparam int CHAN_LO = CTRL_W - 1 - CHAN_W;
  localparam int RNG_BIT = CHAN_LO - 1;
  localparam int BIP_BIT = CHAN_LO - 2;

  logic              active, rise, fall, din_s;
  logic              fr_shifting, byte_done, tx_hunt_en;
  logic [CTRL_W-1:0] byte_q;
  logic [RES_W-1:0]  hold_q, load_word;
  logic              pd_q;

  sadc_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .active(active), .rise(rise), .fall(fall), .din_s(din_s)
  );

  sadc_framer #(.CTRL_W(CTRL_W)) framer_i (
    .clk(clk), .rst(rst), .active(active), .rise(rise), .din_s(din_s),
    .hunt_en(tx_hunt_en), .shifting(fr_shifting), .byte_done(byte_done),
    .byte_q(byte_q)
  );

  // bipolar results leave as two's complement: flip the offset-binary MSB
  assign load_word = bipolar ? {~hold_q[RES_W-1], hold_q[RES_W-2:0]} : hold_q;

  sadc_tx #(.RES_W(RES_W), .OVL_BIT(OVL_BIT)) tx_i (
    .clk(clk), .rst(rst), .active(active), .fall(fall),
    .load_req(byte_done), .load_word(load_word),
    .dout(dout), .hunt_en(tx_hunt_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= '0;
      pd_q      <= 1'b1;
      conv_req  <= 1'b0;
      conv_chan <= '0;
      rng_sel   <= '0;
      bipolar   <= 1'b0;
      pwr_mode  <= PM_NORMAL;
      dout_oe   <= 1'b0;
    end else begin
      dout_oe  <= active;
      conv_req <= byte_done;
      if (res_valid) hold_q <= res_data;
      if (byte_done) begin
        conv_chan <= byte_q[CHAN_HI:CHAN_LO];
        rng_sel   <= {byte_q[RNG_BIT], byte_q[BIP_BIT]};
        bipolar   <= byte_q[BIP_BIT];
        pd_q      <= pd_in;
        pwr_mode  <= decode_pwr(pd_in, byte_q[1:0]);
      end
    end
  end

endmodule

// File: rtl/sadc_serial_if_chk.sv
`timescale 1ns/1ps
module sadc_serial_if_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_req,
  input logic [1:0] rng_sel,
  input logic [2:0] pwr_mode,
  input logic       pd_q,
  input logic       dout,
  input logic       dout_oe,
  input logic       fr_shifting,
  input logic       tx_hunt_en
);
  // R3
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);

  // R3
  fields_move_with_req_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rng_sel) |-> conv_req);

  // R4
  pd_normal_chk: assert property (@(posedge clk) disable iff (rst)
    pd_q |-> (pwr_mode == 3'd0));

  // R4
  pwr_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_mode <= 3'd4);

  // R10
  dout_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !dout_oe |-> !dout);

  // R8
  start_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fr_shifting) |-> $past(tx_hunt_en));

endmodule

bind sadc_serial_if sadc_serial_if_chk chk_i (
  .clk(clk), .rst(rst), .conv_req(conv_req), .rng_sel(rng_sel),
  .pwr_mode(pwr_mode), .pd_q(pd_q), .dout(dout), .dout_oe(dout_oe),
  .fr_shifting(fr_shifting), .tx_hunt_en(tx_hunt_en)
);

// File: tb/sadc_serial_if_tb_top.sv
`timescale 1ns/1ps
module sadc_serial_if_tb_top;
  localparam int HALF = 8;

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [3:0]  nz;
    logic        pd;
    logic [11:0] data;
    logic [11:0] expw;
    logic [1:0]  rng;
    logic [2:0]  pm;
    logic [2:0]  ch;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{ctrl:8'h81, nz:4'd0, pd:1'b1, data:12'hA53, expw:12'hA53, rng:2'd0, pm:3'd0, ch:3'd0},
    '{ctrl:8'h85, nz:4'd3, pd:1'b0, data:12'hA53, expw:12'h253, rng:2'd1, pm:3'd2, ch:3'd0},
    '{ctrl:8'hF8, nz:4'd1, pd:1'b0, data:12'h7FF, expw:12'h7FF, rng:2'd2, pm:3'd1, ch:3'd7},
    '{ctrl:8'h9E, nz:4'd5, pd:1'b0, data:12'h000, expw:12'h800, rng:2'd3, pm:3'd3, ch:3'd1},
    '{ctrl:8'hAF, nz:4'd2, pd:1'b0, data:12'hFFF, expw:12'h7FF, rng:2'd3, pm:3'd4, ch:3'd2},
    '{ctrl:8'hAF, nz:4'd0, pd:1'b1, data:12'h800, expw:12'h000, rng:2'd3, pm:3'd0, ch:3'd2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [11:0] res_data = '0;
  logic res_valid = 1'b0, pd_in = 1'b1;
  logic dout, dout_oe, conv_req, bipolar;
  logic [2:0] conv_chan, pwr_mode;
  logic [1:0] rng_sel;
  int n_chk = 0, n_fail = 0, n_req = 0;
  logic finished = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) if (!rst && conv_req) n_req <= n_req + 1;

  sadc_serial_if dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .dout(dout), .dout_oe(dout_oe), .res_data(res_data), .res_valid(res_valid),
    .pd_in(pd_in), .conv_req(conv_req), .conv_chan(conv_chan),
    .rng_sel(rng_sel), .bipolar(bipolar), .pwr_mode(pwr_mode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one sclk period: din set during low phase, dout sampled late in high phase
  task automatic tick(input logic b, output logic smp);
    din = b;
    idle(HALF);
    sclk = 1'b1;
    idle(HALF - 1);
    smp = dout;
    @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] ctrl, input int nz, output logic [11:0] got,
                      output logic tail);
    logic s;
    cs_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < nz; i++) tick(1'b0, s);
    for (int i = 7; i >= 0; i--) tick(ctrl[i], s);
    for (int i = 11; i >= 0; i--) begin
      tick(1'b0, s);
      got[i] = s;
    end
    tick(1'b0, tail);
    cs_n = 1'b1;
    idle(HALF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [11:0] got, got2;
    logic tail, s;
    int req0;
    idle(5);
    rst = 1'b0;
    idle(3);
    // R11 reset state
    check("R11 dout", dout, 0);
    check("R11 dout_oe", dout_oe, 0);
    check("R11 conv_req", conv_req, 0);
    check("R11 rng_sel", rng_sel, 0);
    check("R11 bipolar", bipolar, 0);
    check("R11 pwr_mode", pwr_mode, 0);
    check("R11 conv_chan", conv_chan, 0);

    // table walk: R1 R2 R4 R5 R6 R7
    foreach (VECS[k]) begin
      res_data = VECS[k].data;
      res_valid = 1'b1;
      pd_in = VECS[k].pd;
      req0 = n_req;
      xfer(VECS[k].ctrl, int'(VECS[k].nz), got, tail);
      check("R5/R6 word", got, VECS[k].expw);
      check("R7 tail zero", tail, 0);
      check("R2 rng_sel", rng_sel, VECS[k].rng);
      check("R2 bipolar", bipolar, VECS[k].rng[0]);
      check("R2 conv_chan", conv_chan, VECS[k].ch);
      check("R4 pwr_mode", pwr_mode, VECS[k].pm);
      check("R3 one request", n_req - req0, 1);
      check("R10 oe off after cs high", dout_oe, 0);
    end

    // R10 abort mid-byte: partial 1111 then cs high
    req0 = n_req;
    cs_n = 1'b0;
    idle(HALF);
    for (int i = 0; i < 4; i++) tick(1'b1, s);
    cs_n = 1'b1;
    idle(2 * HALF);
    check("R10 no request on abort", n_req - req0, 0);
    check("R10 rng_sel kept", rng_sel, 3);
    check("R10 chan kept", conv_chan, 2);
    check("R10 dout_oe low", dout_oe, 0);
    check("R10 dout low", dout, 0);
    // next frame restarts hunting cleanly (R1)
    res_data = 12'h001;
    pd_in = 1'b1;
    xfer(8'h81, 2, got, tail);
    check("R1 clean restart word", got, 12'h001);
    check("R1 clean restart rng", rng_sel, 0);

    // R12 capture only while res_valid
    res_data = 12'h3C3;
    res_valid = 1'b1;
    idle(3);
    res_valid = 1'b0;
    res_data = 12'hFFF;
    xfer(8'h81, 0, got, tail);
    check("R12 held value", got, 12'h3C3);

    // R8 + R9 overlapped transfer
    res_data = 12'h5A3;
    res_valid = 1'b1;
    pd_in = 1'b1;
    req0 = n_req;
    cs_n = 1'b0;
    idle(HALF);
    for (int i = 7; i >= 0; i--) tick(ext8(8'h81, i), s);
    for (int i = 11; i >= 5; i--) begin
      tick(1'b1, s);          // ones before D4 must be ignored
      got[i] = s;
      if (i == 10) begin
        res_data = 12'h123;
        pd_in = 1'b0;
      end
    end
    check("R8 no early request", n_req - req0, 1);
    for (int i = 7; i >= 0; i--) begin   // new byte 0x9D starts with D4 showing
      tick(ext8(8'h9D, i), s);
      if (i >= 3) got[i-3] = s;
    end
    check("R8 first word intact", got, 12'h5A3);
    check("R9 second request", n_req - req0, 2);
    check("R9 second pwr_mode", pwr_mode, 2);
    check("R9 second rng_sel", rng_sel, 3);
    for (int i = 11; i >= 0; i--) begin
      tick(1'b0, s);
      got2[i] = s;
    end
    tick(1'b0, tail);
    check("R9 second word", got2, 12'h923);
    check("R7 tail after overlap", tail, 0);
    cs_n = 1'b1;
    idle(2 * HALF);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  function automatic logic ext8(input logic [7:0] v, input int i);
    return v[i];
  endfunction

endmodule